// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits in the chip-enable path between a host and an external low-power static RAM whose chip-enable input masks all of its other inputs. While supply power is good, the gated chip-enable it drives to the memory tracks the host's active-low chip-enable. When a digital power-fail flag reports that supply has dropped, the block holds the memory deselected (high) so that nothing can be written while the supply collapses.

An access that is already running when the failure is flagged is allowed to finish. This grace period ends either when the host releases chip-enable or when a bounded number of clock cycles has passed, whichever comes first. When power returns, the memory stays deselected for a long, fixed settling period while the processor comes back up. After that period the block resumes tracking only once the host chip-enable is idle, so the memory never sees a truncated cycle. Both inputs pass through two-flop synchronizers. Both periods are parameters counted in clock cycles.

Top module: `pfce_gate`

## Requirements
- R1: While power is good and no protection or settling period is active, `mem_ce_n` equals `host_ce_n` delayed by the synchronizer.
- R2: Once a failure is flagged (`pwr_ok` low) and no access is in flight, `mem_ce_n` is held at 1 whatever `host_ce_n` does.
- R3: If `host_ce_n` is low when the failure is seen, `mem_ce_n` stays low until the host raises `host_ce_n`, and then goes to 1 and stays there.
- R4: An in-flight access left open during a failure is cut off: at most `GRACE_CYC` cycles after the failure takes effect, `mem_ce_n` goes to 1 even with `host_ce_n` still low.
- R5: After `pwr_ok` returns high, `mem_ce_n` stays at 1 for at least `HOLD_CYC` cycles regardless of `host_ce_n`.
- R6: When the settling period has expired, tracking resumes only after `host_ce_n` has been seen high, so a host chip-enable held low across the end of the period is not passed through.
- R7: If `pwr_ok` falls again during the settling period, the period restarts from zero when power next returns.
- R8: A synchronous reset (`rst` high) puts the block in the protected state: `mem_ce_n` = 1 and `wp_active` = 1.
- R9: `wp_active` is 1 exactly while the memory is held protected or settling, and 0 while tracking or in the grace period.
- R10: Each input reaches the output through two synchronizing flops. A change on `host_ce_n` while tracking appears on `mem_ce_n` after the second rising clock edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_ce_n | input | 1 | Host chip-enable, active low, asynchronous |
| pwr_ok | input | 1 | Power-good flag, 1 = supply good, asynchronous |
| mem_ce_n | output | 1 | Gated chip-enable to the memory, active low |
| wp_active | output | 1 | 1 while write protection is asserted |

## Verification
The bench probes the edges of the timed windows. It checks an access that ends on its own inside the grace period and one that would overrun it. A design with no timeout would keep `mem_ce_n` low, and a design with no grace period would cut the access off at once. It holds the host chip-enable low across the end of the settling period, which a design that resumes tracking blindly would pass straight through as a partial cycle. It also makes power fail a second time mid-settling. A design that keeps its old count would then release the memory too early. The two-edge input latency is sampled exactly, so a missing or extra synchronizer stage shows up as a one-cycle shift.

// File: rtl/pfce_gate.sv
module pfce_gate #(
  parameter int unsigned GRACE_CYC = 16,
  parameter int unsigned HOLD_CYC  = 15_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic host_ce_n,
  input  logic pwr_ok,
  output logic mem_ce_n,
  output logic wp_active
);
  localparam int unsigned TOP = (GRACE_CYC > HOLD_CYC) ? GRACE_CYC : HOLD_CYC;
  localparam int CW = $clog2(TOP + 1);

  typedef enum logic [1:0] {ST_RUN, ST_GRACE, ST_LOCK, ST_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    ce_sy, ok_sy;
  logic          ce_s, ok_s;

  assign ce_s = ce_sy[1];
  assign ok_s = ok_sy[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_sy <= 2'b11;
      ok_sy <= 2'b00;
    end else begin
      ce_sy <= {ce_sy[0], host_ce_n};
      ok_sy <= {ok_sy[0], pwr_ok};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_LOCK;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          cnt <= '0;
          if (!ok_s) st <= ce_s ? ST_LOCK : ST_GRACE;
        end
        ST_GRACE: begin
          if (ce_s || cnt == CW'(GRACE_CYC - 1)) begin
            st  <= ST_LOCK;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOCK: begin
          cnt <= '0;
          if (ok_s) st <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!ok_s) begin
            st  <= ST_LOCK;
            cnt <= '0;
          end else if (cnt == CW'(HOLD_CYC)) begin
            if (ce_s) st <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_LOCK;
      endcase
    end
  end

  assign mem_ce_n  = (st == ST_RUN || st == ST_GRACE) ? ce_s : 1'b1;
  assign wp_active = (st == ST_LOCK || st == ST_HOLD);
endmodule

// File: rtl/pfce_gate_chk.sv
module pfce_gate_chk #(
  parameter int unsigned GRACE_CYC = 16,
  parameter int unsigned HOLD_CYC  = 15_000_000
) (
  input logic clk,
  input logic rst,
  input logic pwr_ok,
  input logic mem_ce_n,
  input logic wp_active
);
  int unsigned fail_run, ok_run;

  always_ff @(posedge clk) begin
    if (pwr_ok) fail_run <= 0;
    else if (fail_run < GRACE_CYC + 8) fail_run <= fail_run + 1;
    if (!pwr_ok) ok_run <= 0;
    else if (ok_run < HOLD_CYC + 8) ok_run <= ok_run + 1;
  end

  // R8
  reset_state_chk: assert property (@(posedge clk) rst |=> (wp_active && mem_ce_n));

  // R2
  protect_high_chk: assert property (@(posedge clk) disable iff (rst) wp_active |-> mem_ce_n);

  // R4
  grace_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_run > GRACE_CYC + 2) |-> mem_ce_n);

  // R5
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wp_active) |-> (ok_run >= HOLD_CYC));

  // R6
  idle_resume_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wp_active) |-> mem_ce_n);
endmodule

bind pfce_gate pfce_gate_chk #(.GRACE_CYC(GRACE_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .mem_ce_n(mem_ce_n), .wp_active(wp_active)
);

// File: tb/pfce_gate_test.sv
module pfce_gate_test;
  localparam int unsigned GC = 6;
  localparam int unsigned HC = 20;

  logic clk = 0, rst = 1, host_ce_n = 1, pwr_ok = 1;
  logic mem_ce_n, wp_active;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  typedef struct { logic ce; logic wp; string tag; } exp_t;
  exp_t q[$];
  event chk_ev;

  always #4 clk = ~clk;

  pfce_gate #(.GRACE_CYC(GC), .HOLD_CYC(HC)) uut (
    .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .pwr_ok(pwr_ok),
    .mem_ce_n(mem_ce_n), .wp_active(wp_active)
  );

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (mem_ce_n !== e.ce || wp_active !== e.wp) begin
          n_bad++;
          $display("FAIL %s: mem_ce_n=%b wp_active=%b expected %b %b",
                   e.tag, mem_ce_n, wp_active, e.ce, e.wp);
        end
      end
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic ce, input logic ok, input int n);
    host_ce_n = ce;
    pwr_ok    = ok;
    wait_n(n);
  endtask

  task automatic expect_now(input logic ce, input logic wp, input string tag);
    exp_t e;
    e.ce = ce; e.wp = wp; e.tag = tag;
    q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  initial begin
    @(negedge clk);
    wait_n(3);
    expect_now(1, 1, "R8 reset state");
    rst = 0;
    drive(1, 1, 5);
    drive(0, 1, 4);
    expect_now(1, 1, "R5 host ignored during settling");
    drive(0, 1, 30);
    expect_now(1, 1, "R6 no resume while host active");
    drive(1, 1, 4);
    expect_now(1, 0, "R9 tracking after idle host");
    drive(0, 1, 1);
    expect_now(1, 0, "R10 not yet after one edge");
    wait_n(1);
    expect_now(0, 0, "R1 follows host low");
    drive(1, 1, 4);
    expect_now(1, 0, "R1 follows host high");

    drive(0, 1, 4);
    drive(0, 0, 4);
    expect_now(0, 0, "R3 access continues after failure");
    drive(1, 0, 4);
    expect_now(1, 1, "R3 protected after access ends");
    drive(0, 0, 4);
    expect_now(1, 1, "R2 host ignored during failure");

    drive(1, 1, 12);
    drive(1, 0, 4);
    expect_now(1, 1, "R7 refail during settling");
    drive(1, 1, 12);
    drive(0, 1, 4);
    expect_now(1, 1, "R7 settling restarted");
    drive(0, 1, 30);
    drive(1, 1, 30);
    drive(0, 1, 4);
    expect_now(0, 0, "R1 tracking again");

    drive(0, 0, 6);
    expect_now(0, 0, "R4 inside grace window");
    wait_n(5);
    expect_now(1, 1, "R4 grace timeout");

    drive(1, 1, 30);
    drive(1, 0, 4);
    expect_now(1, 1, "R2 idle failure protects");
    drive(0, 0, 4);
    expect_now(1, 1, "R2 new access blocked");
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expected scenario end, got timeout");
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule